// File: doc/BRIEF.md
# Four-Channel Shadow-Buffered PWM Controller

This block drives four independent pulse-width modulated outputs from one clock, programmed over a simple word-addressed register bus with separate read and write strobes. Each channel has its own power-of-two clock divider, a 16-bit tick counter, a period length and a duty count. The duty count gives how many ticks at the start of each period the output stays at its inactive level. After that the output sits at its active level until the period wraps. A polarity bit in the channel's mode register chooses which level counts as active.

Software can reload period and duty in two ways. A direct write lands at once. A write to an update register is held and taken in at the next period boundary, so a running waveform never shows a torn cycle. Channels are started and stopped through bitmask registers. A stop request takes effect only when the current period completes. A per-channel period-end flag register records every boundary and clears when it is read, so software can tell when a reload has been taken in.

Top module: `pwm4_ctrl`

## Requirements
- R1: After a synchronous active-high reset every channel is stopped, every channel register reads zero, all `pwm_o` bits are 0, and `bus_rdata` is 0.
- R2: A write to offset 0x004 starts channel n for every set bit n of the data, and a write to 0x008 requests a stop for every set bit n. Zero bits in either write leave their channel untouched. Offset 0x00C reads back the running state, with bit n set while channel n runs.
- R3: Channel n's registers sit at 0x200 + n*0x20. The mode register is at +0x00, with bits [3:0] as the prescale exponent and bit 9 as polarity. Duty is at +0x04, duty update at +0x08, period at +0x0C and period update at +0x10. Each reads back the value last stored in it. A read returns data in `bus_rdata` on the clock after `bus_rd`, and `bus_rdata` is 0 in any cycle that follows no read.
- R4: A running channel advances its counter once every 2^p clocks, where p is the prescale exponent and any value above 10 acts as 10. A period spans P ticks, and P = 0 acts as 1. Starting a stopped channel restarts its counter and divider from zero.
- R5: Within a period the output is at its inactive level while the count is below duty and at its active level otherwise, so duty >= period gives a constant inactive level. With polarity 0 the active level is 1; with polarity 1 it is 0. A stopped channel holds its inactive level. `pwm_o` is registered, one clock behind the counter state.
- R6: Direct writes to period or duty take effect at once. A value written to an update register is moved into period or duty only at the end of the channel's current period.
- R7: Bit n of the flag register at 0x01C is set at every period end of channel n. Reading 0x01C returns the flags and clears them, but a period end in the same cycle as the read leaves its bit set.
- R8: After a stop request the channel keeps running, and its status bit stays 1, until the current period ends. Only then do the channel and its status bit drop to 0. A start written while a stop is pending cancels the stop.
- R9: Reads of any offset not listed in R2, R3 or R7 return 0, and writes to such offsets change nothing. The start and stop registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; the flag register clears on a read |
| bus_rdata | output | 32 | Registered read data, valid the clock after `bus_rd` |
| pwm_o | output | 4 | Registered waveform output, one bit per channel |

## Verification
The bench uses the default parameters: four channels, 16-bit counts, a 4-bit prescale field and a largest exponent of 10. At these values an out-of-range exponent of 15 is reachable and must act as 10, which gives periods of 2048 clocks that the bench measures directly. The 16-bit period lets a 1000-tick period hold a pending update long enough to show that it is not applied early. With all four channels running at different periods, flag reads land in the same cycle as period ends, and the cycle-accurate model checks those cases on every clock.

// File: rtl/pwm4_pkg.sv
`timescale 1ns/1ps
package pwm4_pkg;
  // global register offsets
  localparam int unsigned OFS_START  = 32'h004;
  localparam int unsigned OFS_STOP   = 32'h008;
  localparam int unsigned OFS_STAT   = 32'h00C;
  localparam int unsigned OFS_FLAG   = 32'h01C;
  // channel window
  localparam int unsigned CH_BASE    = 32'h200;
  localparam int unsigned CH_STRIDE  = 32'h020;
  // offsets inside one channel window
  localparam int unsigned OFS_MODE    = 32'h00;
  localparam int unsigned OFS_DUTY    = 32'h04;
  localparam int unsigned OFS_DUTY_NX = 32'h08;
  localparam int unsigned OFS_PER     = 32'h0C;
  localparam int unsigned OFS_PER_NX  = 32'h10;
  // polarity bit position in the mode register
  localparam int unsigned POL_BIT     = 9;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_DUTY, SEL_DUTY_NX, SEL_PER, SEL_PER_NX
  } chan_sel_e;
endpackage

// File: rtl/pwm4_chan.sv
`timescale 1ns/1ps
module pwm4_chan
  import pwm4_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int MAX_PRE = 10,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  chan_sel_e         sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              run_o,
  output logic              end_o,
  output logic              pwm_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int DIV_W = MAX_PRE + 1;

  logic             run_q, stop_q, pol_q, pwm_q;
  logic [PRE_W-1:0] pre_q, eff_pre;
  logic [CNT_W-1:0] per_q, duty_q, per_nx_q, duty_nx_q, cnt_q;
  logic             per_pend_q, duty_pend_q;
  logic [DIV_W-1:0] div_q, tick_lim;
  logic [CNT_W:0]   cnt_inc;
  logic             tick, end_w;
  logic             wr_mode, wr_duty, wr_duty_nx, wr_per, wr_per_nx;

  assign eff_pre  = (pre_q > PRE_W'(MAX_PRE)) ? PRE_W'(MAX_PRE) : pre_q;
  assign tick_lim = ~({DIV_W{1'b1}} << eff_pre);
  assign tick     = run_q && (div_q == tick_lim);
  assign cnt_inc  = (CNT_W+1)'(cnt_q) + (CNT_W+1)'(1);
  assign end_w    = tick && (cnt_inc >= (CNT_W+1)'(per_q));

  assign wr_mode    = wr_i && (sel_i == SEL_MODE);
  assign wr_duty    = wr_i && (sel_i == SEL_DUTY);
  assign wr_duty_nx = wr_i && (sel_i == SEL_DUTY_NX);
  assign wr_per     = wr_i && (sel_i == SEL_PER);
  assign wr_per_nx  = wr_i && (sel_i == SEL_PER_NX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; stop_q <= 1'b0; pol_q <= 1'b0; pwm_q <= 1'b0;
      pre_q <= '0; per_q <= '0; duty_q <= '0; per_nx_q <= '0; duty_nx_q <= '0;
      cnt_q <= '0; div_q <= '0; per_pend_q <= 1'b0; duty_pend_q <= 1'b0;
    end else begin
      pwm_q <= (run_q && (cnt_q >= duty_q)) ? ~pol_q : pol_q;
      // tick and period counting
      if (run_q) begin
        if (tick) begin
          div_q <= '0;
          cnt_q <= end_w ? '0 : cnt_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
      // start / stop sequencing
      if (start_i) begin
        run_q  <= 1'b1;
        stop_q <= 1'b0;
        if (!run_q) begin
          cnt_q <= '0;
          div_q <= '0;
        end
      end else if (end_w && stop_q) begin
        run_q  <= 1'b0;
        stop_q <= 1'b0;
      end else if (stop_i && run_q) begin
        stop_q <= 1'b1;
      end
      // boundary reloads, bus writes take priority
      if (end_w && per_pend_q) begin
        per_q      <= per_nx_q;
        per_pend_q <= 1'b0;
      end
      if (end_w && duty_pend_q) begin
        duty_q      <= duty_nx_q;
        duty_pend_q <= 1'b0;
      end
      if (wr_per)  per_q  <= wdata_i[CNT_W-1:0];
      if (wr_duty) duty_q <= wdata_i[CNT_W-1:0];
      if (wr_per_nx) begin
        per_nx_q   <= wdata_i[CNT_W-1:0];
        per_pend_q <= 1'b1;
      end
      if (wr_duty_nx) begin
        duty_nx_q   <= wdata_i[CNT_W-1:0];
        duty_pend_q <= 1'b1;
      end
      if (wr_mode) begin
        pre_q <= wdata_i[PRE_W-1:0];
        pol_q <= wdata_i[POL_BIT];
      end
    end
  end

  always_comb begin
    rd_o = '0;
    case (sel_i)
      SEL_MODE: begin
        rd_o[PRE_W-1:0] = pre_q;
        rd_o[POL_BIT]   = pol_q;
      end
      SEL_DUTY:    rd_o[CNT_W-1:0] = duty_q;
      SEL_DUTY_NX: rd_o[CNT_W-1:0] = duty_nx_q;
      SEL_PER:     rd_o[CNT_W-1:0] = per_q;
      SEL_PER_NX:  rd_o[CNT_W-1:0] = per_nx_q;
      default:     rd_o = '0;
    endcase
  end

  assign run_o = run_q;
  assign end_o = end_w;
  assign pwm_o = pwm_q;

  // R8: a channel only stops at the end of a period with a stop pending
  p_stop_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(end_w && stop_q));
  // R8: a running channel keeps running unless it reaches a stopping end
  p_run_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run_q && !(end_w && stop_q)) |=> run_q);
  // R5: a stopped channel shows its inactive level
  p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (pwm_q == $past(pol_q)));
  // R6: pending duty is taken in at the boundary
  p_duty_apply_r6: assert property (@(posedge clk) disable iff (rst)
    (end_w && duty_pend_q && !wr_duty) |=> (duty_q == $past(duty_nx_q)));
endmodule

// File: rtl/pwm4_flags.sv
`timescale 1ns/1ps
module pwm4_flags #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_i,
  output logic [NCH-1:0] flags_o
);
  logic [NCH-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end

  assign flags_o = flags_q;

  // R7: a new event survives a same-cycle read clear
  p_set_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
  // R7: a read with no new event leaves the register empty
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (set_i == '0)) |=> (flags_o == '0));
endmodule

// File: rtl/pwm4_ctrl.sv
`timescale 1ns/1ps
module pwm4_ctrl
  import pwm4_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 4,
  parameter int MAX_PRE = 10,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  localparam int CH_W   = $clog2(NCH);
  localparam int CH_SH  = $clog2(CH_STRIDE);
  localparam int CH_END = CH_BASE + NCH * CH_STRIDE;

  logic              in_ch;
  logic [CH_W-1:0]   ch_idx;
  logic [CH_SH-1:0]  ofs;
  chan_sel_e         csel;
  logic              is_start, is_stop, is_flag_rd;
  logic [NCH-1:0]    run_v, end_v, pwm_v, flags;
  logic [DATA_W-1:0] chan_rd [NCH];
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              legal_rd;

  assign in_ch  = (bus_addr >= ADDR_W'(CH_BASE)) && (bus_addr < ADDR_W'(CH_END));
  assign ch_idx = bus_addr[CH_SH +: CH_W];
  assign ofs    = bus_addr[CH_SH-1:0];

  always_comb begin
    csel = SEL_NONE;
    if (in_ch) begin
      case (ofs)
        CH_SH'(OFS_MODE):    csel = SEL_MODE;
        CH_SH'(OFS_DUTY):    csel = SEL_DUTY;
        CH_SH'(OFS_DUTY_NX): csel = SEL_DUTY_NX;
        CH_SH'(OFS_PER):     csel = SEL_PER;
        CH_SH'(OFS_PER_NX):  csel = SEL_PER_NX;
        default:             csel = SEL_NONE;
      endcase
    end
  end

  assign is_start   = bus_wr && (bus_addr == ADDR_W'(OFS_START));
  assign is_stop    = bus_wr && (bus_addr == ADDR_W'(OFS_STOP));
  assign is_flag_rd = bus_rd && (bus_addr == ADDR_W'(OFS_FLAG));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_sel_e sel_g;
    assign sel_g = (ch_idx == CH_W'(g)) ? csel : SEL_NONE;
    pwm4_chan #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .MAX_PRE(MAX_PRE), .DATA_W(DATA_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .sel_i   (sel_g),
      .wr_i    (bus_wr),
      .wdata_i (bus_wdata),
      .start_i (is_start && bus_wdata[g]),
      .stop_i  (is_stop && bus_wdata[g]),
      .run_o   (run_v[g]),
      .end_o   (end_v[g]),
      .pwm_o   (pwm_v[g]),
      .rd_o    (chan_rd[g])
    );
  end

  pwm4_flags #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (end_v),
    .clr_i   (is_flag_rd),
    .flags_o (flags)
  );

  always_comb begin
    rd_mux   = '0;
    legal_rd = 1'b0;
    if (bus_addr == ADDR_W'(OFS_STAT)) begin
      rd_mux   = DATA_W'(run_v);
      legal_rd = 1'b1;
    end else if (bus_addr == ADDR_W'(OFS_FLAG)) begin
      rd_mux   = DATA_W'(flags);
      legal_rd = 1'b1;
    end else if (csel != SEL_NONE) begin
      rd_mux   = chan_rd[ch_idx];
      legal_rd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign pwm_o     = pwm_v;

  // R9: undefined offsets read back as zero
  p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !legal_rd) |=> (bus_rdata == '0));
  // R3: no read, no data
  p_idle_rdata_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/pwm4_ctrl_tb.sv
`timescale 1ns/1ps
module pwm4_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm4_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_run[4], m_stop[4], m_pol[4], m_pre[4], m_per[4], m_duty[4];
  int m_pnx[4], m_dnx[4], m_pp[4], m_dp[4], m_cnt[4], m_div[4];
  int m_flags;
  logic [3:0]  m_out;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input int a);
    int c, o;
    if (a == 'h00C) begin
      model_read = '0;
      for (int k = 0; k < 4; k++) model_read[k] = (m_run[k] != 0);
      return model_read;
    end
    if (a == 'h01C) return 32'(m_flags);
    if (a >= 'h200 && a < 'h280) begin
      c = (a - 'h200) / 32;
      o = (a - 'h200) % 32;
      case (o)
        0:  return 32'((m_pol[c] << 9) | m_pre[c]);
        4:  return 32'(m_duty[c]);
        8:  return 32'(m_dnx[c]);
        12: return 32'(m_per[c]);
        16: return 32'(m_pnx[c]);
        default: return '0;
      endcase
    end
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_run[c] = 0; m_stop[c] = 0; m_pol[c] = 0; m_pre[c] = 0; m_per[c] = 0;
        m_duty[c] = 0; m_pnx[c] = 0; m_dnx[c] = 0; m_pp[c] = 0; m_dp[c] = 0;
        m_cnt[c] = 0; m_div[c] = 0;
      end
      m_flags = 0; m_out = '0; m_rdata = '0;
    end else begin
      logic [31:0] rv;
      int ev, a, w, eff, base;
      a  = int'(bus_addr);
      w  = int'(bus_wdata);
      rv = model_read(a);
      ev = 0;
      for (int c = 0; c < 4; c++) begin
        base = 'h200 + c * 'h20;
        m_out[c] = (m_run[c] != 0 && m_cnt[c] >= m_duty[c]) ? !m_pol[c][0] : m_pol[c][0];
        if (m_run[c] != 0) begin
          eff = (m_pre[c] > 10) ? 10 : m_pre[c];
          if (m_div[c] == (1 << eff) - 1) begin
            m_div[c] = 0;
            if (m_cnt[c] + 1 >= m_per[c]) begin
              m_cnt[c] = 0;
              ev |= (1 << c);
              if (m_pp[c] != 0) begin m_per[c] = m_pnx[c]; m_pp[c] = 0; end
              if (m_dp[c] != 0) begin m_duty[c] = m_dnx[c]; m_dp[c] = 0; end
              if (m_stop[c] != 0) begin m_run[c] = 0; m_stop[c] = 0; end
            end else m_cnt[c]++;
          end else m_div[c]++;
        end
        if (bus_wr) begin
          if (a == 'h004 && bus_wdata[c]) begin
            if (m_run[c] == 0) begin m_cnt[c] = 0; m_div[c] = 0; end
            m_run[c] = 1; m_stop[c] = 0;
          end
          if (a == 'h008 && bus_wdata[c] && m_run[c] != 0) m_stop[c] = 1;
          if (a == base)        begin m_pre[c] = w & 'hF; m_pol[c] = (w >> 9) & 1; end
          if (a == base + 'h04) m_duty[c] = w & 'hFFFF;
          if (a == base + 'h08) begin m_dnx[c] = w & 'hFFFF; m_dp[c] = 1; end
          if (a == base + 'h0C) m_per[c] = w & 'hFFFF;
          if (a == base + 'h10) begin m_pnx[c] = w & 'hFFFF; m_pp[c] = 1; end
        end
      end
      m_flags = ((bus_rd && a == 'h01C) ? 0 : m_flags) | ev;
      m_rdata = bus_rd ? rv : '0;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pwm_o !== m_out) begin
        errors++;
        $display("FAIL R5 waveform: pwm_o actual %b expected %b at %0t", pwm_o, m_out, $time);
      end
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R3 read data: actual %h expected %h at %0t", bus_rdata, m_rdata, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o[ch]) hi++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [31:0] d;
    int hi;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    expect_eq("R1 outputs after reset", 32'(pwm_o), 0);
    bus_read('h00C, d); expect_eq("R1 status after reset", d, 0);
    bus_read('h20C, d); expect_eq("R1 period after reset", d, 0);

    // R3: channel 0 register map and readback
    bus_write('h20C, 5);
    bus_write('h204, 2);
    bus_read('h20C, d); expect_eq("R3 period readback", d, 5);
    bus_write('h200, 'h20F);
    bus_read('h200, d); expect_eq("R3 mode readback", d, 'h20F);
    bus_write('h200, 0);

    // R2: start channel 0
    bus_write('h004, 1);
    bus_read('h00C, d); expect_eq("R2 status after start", d, 1);
    // R5: 3 of 5 ticks active
    repeat (10) @(negedge clk);
    count_high(0, 20, hi); expect_eq("R5 active count duty 2 of 5", 32'(hi), 12);
    // R2: zero bits have no effect
    bus_write('h004, 0);
    bus_read('h00C, d); expect_eq("R2 zero bits ignored", d, 1);

    // R9: undefined offsets
    bus_read('h100, d); expect_eq("R9 undefined read", d, 0);
    bus_read('h004, d); expect_eq("R9 start reg reads zero", d, 0);
    bus_write('h214, 9);
    bus_read('h20C, d); expect_eq("R9 undefined channel write", d, 5);
    bus_write('h100, 'hF);
    bus_read('h00C, d); expect_eq("R9 undefined global write", d, 1);

    // R6: shadow updates wait for the boundary
    bus_write('h20C, 1000);
    bus_write('h208, 7);
    bus_write('h210, 5);
    bus_read('h204, d); expect_eq("R6 duty not yet updated", d, 2);
    bus_read('h20C, d); expect_eq("R6 period not yet updated", d, 1000);
    bus_read('h208, d); expect_eq("R3 duty update readback", d, 7);
    repeat (1100) @(negedge clk);
    bus_read('h204, d); expect_eq("R6 duty taken at boundary", d, 7);
    bus_read('h20C, d); expect_eq("R6 period taken at boundary", d, 5);

    // R7: period flag
    repeat (10) @(negedge clk);
    bus_read('h01C, d); expect_eq("R7 flag set", d & 1, 1);

    // R8: stop waits for the period end
    bus_write('h008, 1);
    bus_read('h00C, d); expect_eq("R8 status held during stop", d, 1);
    repeat (10) @(negedge clk);
    bus_read('h00C, d); expect_eq("R8 stopped after period", d, 0);
    expect_eq("R5 stopped output inactive", 32'(pwm_o[0]), 0);
    bus_read('h01C, d);
    bus_read('h01C, d); expect_eq("R7 cleared on read", d, 0);

    // R5: inverted polarity, duty equal to period
    bus_write('h220, 'h200);
    bus_write('h22C, 4);
    bus_write('h224, 4);
    repeat (2) @(negedge clk);
    expect_eq("R5 inverted idle level", 32'(pwm_o[1]), 1);
    bus_write('h004, 2);
    count_high(1, 12, hi); expect_eq("R5 zero active inverted", 32'(hi), 12);

    // R4: prescale exponent 1
    bus_write('h240, 1);
    bus_write('h24C, 3);
    bus_write('h244, 1);
    bus_write('h004, 4);
    repeat (10) @(negedge clk);
    count_high(2, 24, hi); expect_eq("R4 prescale 2 clocks per tick", 32'(hi), 16);

    // R8: start during a pending stop keeps the channel running
    bus_write('h008, 4);
    bus_write('h004, 4);
    repeat (20) @(negedge clk);
    bus_read('h00C, d); expect_eq("R8 start cancels stop", d & 4, 4);

    // R7: repeated flag reads race period ends (checked cycle by cycle)
    for (int i = 0; i < 40; i++) bus_read('h01C, d);

    // R4: exponent 15 acts as 10
    bus_write('h260, 15);
    bus_write('h26C, 2);
    bus_write('h264, 1);
    bus_write('h004, 8);
    repeat (3000) @(negedge clk);
    count_high(3, 4096, hi); expect_eq("R4 exponent clamps to 10", 32'(hi), 2048);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule